// File: doc/BRIEF.md
# Nibble Accumulator Datapath

This block is the arithmetic and register core of a small 4-bit controller. It keeps an accumulator, a carry flag, a second nibble register, an 8-bit pair register and a 3-bit page pointer. Each cycle it takes a decoded operation code together with its operands: a data-memory nibble, an immediate nibble, a 7-bit page immediate, and table data returned by program ROM. It then updates its registers. Most operations finish in the cycle they are issued.

The table-read operation takes two phases. The block first issues a one-cycle ROM request with an address formed from the page immediate, the pointer register and the accumulator. It then waits, marked busy, until the ROM reply arrives. The reply is split across the accumulator, the second nibble register and the pointer. Instruction fetch, data RAM, ports and the program counter lie outside the block.

Top module: `nib_acc_core`

## Requirements
- R1: When reset is released, the accumulator is 0, the carry flag is 0, and `rom_req`, `busy` and `eq_o` are all low. The B, E and D registers have no defined reset value.
- R2: Op 1 (add with carry) writes (A + M + carry) mod 16 to A. It writes the carry out of bit 3 to the carry flag.
- R3: Op 2 (add immediate) writes (A + imm) mod 16 to A. Op 3 (add memory) writes (A + M) mod 16 to A. Neither op changes the carry flag.
- R4: Op 4 writes A AND M to A. Op 5 writes A OR M to A. Neither op changes the carry flag.
- R5: Op 6 (compare) raises `eq_o` for exactly the next cycle when A equals M. It changes neither A nor the carry flag.
- R6: Op 7 (rotate right through carry) makes the carry flag equal to the old A[0] and A equal to {old carry, old A[3:1]}.
- R7: Op 8 sets the carry flag to 1 and op 9 clears it to 0. Neither op changes A.
- R8: Op 10 loads E with {B, A}, with B as the high nibble. Op 11 loads B from E[7:4] and A from E[3:0].
- R9: Op 12 copies B into A. Op 13 copies A into B.
- R10: Op 14 (table read) raises `rom_req` for exactly the next cycle and sets `busy`. In that cycle `rom_addr` = {page[6:0], D[2:0], A[3:0]}, with the page in bits 13:7.
- R11: While `busy` is high, the first cycle with `rom_valid` high writes `rom_data[3:0]` to A, `rom_data[7:4]` to B and {0, `rom_data[9:8]`} to D. It clears `busy` on the next cycle. The carry flag does not change.
- R12: While `busy` is high, operation codes are ignored. While `busy` is low, `rom_valid` is ignored.
- R13: Op 0 and op 15 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Decoded operation, sampled each cycle |
| mem_nib | input | 4 | Data-memory operand nibble |
| imm_nib | input | 4 | Immediate operand nibble |
| page_imm | input | 7 | Page immediate for table read |
| rom_valid | input | 1 | ROM reply valid |
| rom_data | input | 10 | ROM reply data |
| acc_o | output | 4 | Accumulator |
| cy_o | output | 1 | Carry flag |
| b_o | output | 4 | B register |
| e_o | output | 8 | E register |
| d_o | output | 3 | D pointer register |
| eq_o | output | 1 | One-cycle compare-equal pulse |
| rom_req | output | 1 | One-cycle ROM request strobe |
| rom_addr | output | 14 | ROM address for the table read |
| busy | output | 1 | Table read waiting for its reply |

## Verification
The hardest state to reach from the ports is a table read whose address depends on the D register. D has no reset value, and a table reply is the only way to write it. The stimulus therefore runs one table read first to seed D with a known value from its reply, and then runs a second read whose address is checked in full. During the wait for the first reply, the bench issues arithmetic ops that must be dropped. It also issues a reply pulse while the block is idle, to show that the pulse is ignored.

// File: rtl/nib_pkg.sv
package nib_pkg;
   typedef enum logic [3:0] {
      OP_NOP      = 4'd0,
      OP_ADC      = 4'd1,
      OP_ADDI     = 4'd2,
      OP_ADDM     = 4'd3,
      OP_AND      = 4'd4,
      OP_OR       = 4'd5,
      OP_CMP      = 4'd6,
      OP_RAR      = 4'd7,
      OP_SETC     = 4'd8,
      OP_CLRC     = 4'd9,
      OP_PACK_E   = 4'd10,
      OP_UNPACK_E = 4'd11,
      OP_B2A      = 4'd12,
      OP_A2B      = 4'd13,
      OP_TBL      = 4'd14
   } nib_op_e;
endpackage

// File: rtl/nib_alu.sv
module nib_alu #(
   parameter int NIB_W = 4
) (
   input  logic [3:0]       op,
   input  logic [NIB_W-1:0] a,
   input  logic             cy,
   input  logic [NIB_W-1:0] m,
   input  logic [NIB_W-1:0] imm,
   input  logic [NIB_W-1:0] b,
   input  logic [NIB_W-1:0] e_lo,
   output logic [NIB_W-1:0] a_nxt,
   output logic             a_we,
   output logic             cy_nxt,
   output logic             cy_we,
   output logic             eq_hit
);
   import nib_pkg::*;

   logic [NIB_W:0] sum_c;
   assign sum_c = {1'b0, a} + {1'b0, m} + {{NIB_W{1'b0}}, cy};

   always_comb begin
      a_nxt  = a;
      a_we   = 1'b0;
      cy_nxt = cy;
      cy_we  = 1'b0;
      eq_hit = 1'b0;
      case (op)
         OP_ADC: begin
            a_nxt  = sum_c[NIB_W-1:0];
            a_we   = 1'b1;
            cy_nxt = sum_c[NIB_W];
            cy_we  = 1'b1;
         end
         OP_ADDI: begin a_nxt = a + imm; a_we = 1'b1; end
         OP_ADDM: begin a_nxt = a + m;   a_we = 1'b1; end
         OP_AND:  begin a_nxt = a & m;   a_we = 1'b1; end
         OP_OR:   begin a_nxt = a | m;   a_we = 1'b1; end
         OP_CMP:  eq_hit = (a == m);
         OP_RAR: begin
            a_nxt  = {cy, a[NIB_W-1:1]};
            a_we   = 1'b1;
            cy_nxt = a[0];
            cy_we  = 1'b1;
         end
         OP_SETC: begin cy_nxt = 1'b1; cy_we = 1'b1; end
         OP_CLRC: begin cy_nxt = 1'b0; cy_we = 1'b1; end
         OP_B2A:      begin a_nxt = b;    a_we = 1'b1; end
         OP_UNPACK_E: begin a_nxt = e_lo; a_we = 1'b1; end
         default: ;
      endcase
   end
endmodule

// File: rtl/nib_tbl_seq.sv
module nib_tbl_seq #(
   parameter int NIB_W   = 4,
   parameter int D_W     = 3,
   parameter int PAGE_W  = 7,
   parameter int ROM_D_W = 10,
   localparam int ROM_A_W = PAGE_W + D_W + NIB_W,
   localparam int HI_W    = ROM_D_W - 2*NIB_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [PAGE_W-1:0]  page,
   input  logic [D_W-1:0]     d_cur,
   input  logic [NIB_W-1:0]   a_cur,
   input  logic               rom_valid,
   input  logic [ROM_D_W-1:0] rom_data,
   output logic               rom_req,
   output logic [ROM_A_W-1:0] rom_addr,
   output logic               busy,
   output logic               wr,
   output logic [NIB_W-1:0]   a_val,
   output logic [NIB_W-1:0]   b_val,
   output logic [D_W-1:0]     d_val
);
   if (HI_W < 1 || HI_W >= D_W) begin : g_bad_split
      $error("table data high part must be narrower than D");
   end

   assign wr    = busy && rom_valid;
   assign a_val = rom_data[NIB_W-1:0];
   assign b_val = rom_data[2*NIB_W-1:NIB_W];
   assign d_val = {{(D_W-HI_W){1'b0}}, rom_data[ROM_D_W-1:2*NIB_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rom_req  <= 1'b0;
         rom_addr <= '0;
         busy     <= 1'b0;
      end else begin
         rom_req <= start;
         if (start) begin
            rom_addr <= {page, d_cur, a_cur};
            busy     <= 1'b1;
         end else if (wr) begin
            busy <= 1'b0;
         end
      end
   end

   // R10
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rom_req |=> !rom_req);
   // R10
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rom_req |-> busy);
   // R11
   reply_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rom_valid) |=> !busy);
endmodule

// File: rtl/nib_regs.sv
module nib_regs #(
   parameter int NIB_W   = 4,
   parameter int D_W     = 3,
   parameter bit RST_ALL = 1'b0,
   localparam int E_W = 2*NIB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             b_we,
   input  logic [NIB_W-1:0] b_d,
   input  logic             e_we,
   input  logic [E_W-1:0]   e_d,
   input  logic             d_we,
   input  logic [D_W-1:0]   d_d,
   output logic [NIB_W-1:0] b_q,
   output logic [E_W-1:0]   e_q,
   output logic [D_W-1:0]   d_q
);
   if (RST_ALL) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            b_q <= '0;
            e_q <= '0;
            d_q <= '0;
         end else begin
            if (b_we) b_q <= b_d;
            if (e_we) e_q <= e_d;
            if (d_we) d_q <= d_d;
         end
      end
   end else begin : g_norst
      always_ff @(posedge clk) begin
         if (b_we) b_q <= b_d;
         if (e_we) e_q <= e_d;
         if (d_we) d_q <= d_d;
      end
   end

   // R11
   d_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_we |=> (d_q[D_W-1] == 1'b0));
endmodule

// File: rtl/nib_acc_core.sv
module nib_acc_core #(
   parameter int NIB_W   = 4,
   parameter int D_W     = 3,
   parameter int PAGE_W  = 7,
   parameter bit RST_ALL = 1'b0,
   localparam int E_W     = 2*NIB_W,
   localparam int ROM_D_W = 2*NIB_W + 2,
   localparam int ROM_A_W = PAGE_W + D_W + NIB_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         op_code,
   input  logic [NIB_W-1:0]   mem_nib,
   input  logic [NIB_W-1:0]   imm_nib,
   input  logic [PAGE_W-1:0]  page_imm,
   input  logic               rom_valid,
   input  logic [ROM_D_W-1:0] rom_data,
   output logic [NIB_W-1:0]   acc_o,
   output logic               cy_o,
   output logic [NIB_W-1:0]   b_o,
   output logic [E_W-1:0]     e_o,
   output logic [D_W-1:0]     d_o,
   output logic               eq_o,
   output logic               rom_req,
   output logic [ROM_A_W-1:0] rom_addr,
   output logic               busy
);
   import nib_pkg::*;

   if (NIB_W < 2) begin : g_bad_nib
      $error("NIB_W must be at least 2");
   end
   if (PAGE_W < 1) begin : g_bad_page
      $error("PAGE_W must be at least 1");
   end

   logic [NIB_W-1:0] acc_q, a_nxt, t_a, t_b, b_d;
   logic [D_W-1:0]   t_d;
   logic             cy_q, cy_nxt, a_we, cy_we, eq_hit, eq_q;
   logic             live, t_wr, b_we, e_we, start;

   assign live  = !busy;
   assign start = live && (op_code == OP_TBL);

   nib_alu #(.NIB_W(NIB_W)) u_alu (
      .op(op_code), .a(acc_q), .cy(cy_q), .m(mem_nib), .imm(imm_nib),
      .b(b_o), .e_lo(e_o[NIB_W-1:0]),
      .a_nxt(a_nxt), .a_we(a_we), .cy_nxt(cy_nxt), .cy_we(cy_we),
      .eq_hit(eq_hit)
   );

   nib_tbl_seq #(.NIB_W(NIB_W), .D_W(D_W), .PAGE_W(PAGE_W),
                 .ROM_D_W(ROM_D_W)) u_tbl (
      .clk(clk), .rst_n(rst_n), .start(start), .page(page_imm),
      .d_cur(d_o), .a_cur(acc_q), .rom_valid(rom_valid),
      .rom_data(rom_data), .rom_req(rom_req), .rom_addr(rom_addr),
      .busy(busy), .wr(t_wr), .a_val(t_a), .b_val(t_b), .d_val(t_d)
   );

   always_comb begin
      b_we = 1'b0;
      b_d  = acc_q;
      if (t_wr) begin
         b_we = 1'b1;
         b_d  = t_b;
      end else if (live && op_code == OP_A2B) begin
         b_we = 1'b1;
      end else if (live && op_code == OP_UNPACK_E) begin
         b_we = 1'b1;
         b_d  = e_o[E_W-1:NIB_W];
      end
   end
   assign e_we = live && (op_code == OP_PACK_E);

   nib_regs #(.NIB_W(NIB_W), .D_W(D_W), .RST_ALL(RST_ALL)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .b_we(b_we), .b_d(b_d),
      .e_we(e_we), .e_d({b_o, acc_q}),
      .d_we(t_wr), .d_d(t_d),
      .b_q(b_o), .e_q(e_o), .d_q(d_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         cy_q  <= 1'b0;
         eq_q  <= 1'b0;
      end else begin
         eq_q <= live && eq_hit;
         if (t_wr)
            acc_q <= t_a;
         else if (live && a_we)
            acc_q <= a_nxt;
         if (live && cy_we)
            cy_q <= cy_nxt;
      end
   end

   assign acc_o = acc_q;
   assign cy_o  = cy_q;
   assign eq_o  = eq_q;

   // R3
   cy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && (op_code == OP_ADDI || op_code == OP_ADDM || op_code == OP_AND ||
                op_code == OP_OR || op_code == OP_CMP)) |=> $stable(cy_o));
   // R7
   setc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && op_code == OP_SETC) |=> (cy_o && $stable(acc_o)));
   // R7
   clrc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && op_code == OP_CLRC) |=> (!cy_o && $stable(acc_o)));
   // R5
   eq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eq_o |-> ($past(op_code) == OP_CMP));
   // R12
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rom_valid) |=> ($stable(acc_o) && $stable(cy_o)));
   // R13
   bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && (op_code == 4'd15 || op_code == OP_NOP))
         |=> ($stable(acc_o) && $stable(cy_o) && !rom_req));
endmodule

// File: tb/sim_nib_acc_core.sv
module sim_nib_acc_core;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_code = 4'd0, mem_nib = 4'd0, imm_nib = 4'd0;
   logic [6:0] page_imm = 7'd0;
   logic       rom_valid = 1'b0;
   logic [9:0] rom_data = 10'd0;
   logic [3:0] acc_o, b_o;
   logic       cy_o, eq_o, rom_req, busy;
   logic [7:0] e_o;
   logic [2:0] d_o;
   logic [13:0] rom_addr;

   always #(CLK_P/2) clk = ~clk;

   nib_acc_core u0 (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .mem_nib(mem_nib),
      .imm_nib(imm_nib), .page_imm(page_imm), .rom_valid(rom_valid),
      .rom_data(rom_data), .acc_o(acc_o), .cy_o(cy_o), .b_o(b_o), .e_o(e_o),
      .d_o(d_o), .eq_o(eq_o), .rom_req(rom_req), .rom_addr(rom_addr),
      .busy(busy)
   );

   typedef struct {
      string      tag;
      logic [3:0] a, b;
      logic       cy, eq;
      logic [7:0] e;
      logic [2:0] d;
      bit         bk, ek, dk;
   } exp_t;
   exp_t q[$];

   int checks = 0, fails = 0;
   bit done = 0;
   logic [3:0] ma = 0, mb = 0;
   logic       mcy = 0;
   logic [7:0] me = 0;
   logic [2:0] md = 0;
   bit bk = 0, ek = 0, dk = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic push(input string tag, input logic eq);
      exp_t x;
      x.tag = tag; x.a = ma; x.b = mb; x.cy = mcy; x.eq = eq;
      x.e = me; x.d = md; x.bk = bk; x.ek = ek; x.dk = dk;
      q.push_back(x);
   endtask

   // monitor: pops one expected item per completed operation
   always @(negedge clk) begin
      exp_t x;
      if (q.size() > 0) begin
         x = q.pop_front();
         chk(acc_o == x.a, {x.tag, " acc"}, 32'(acc_o), 32'(x.a));
         chk(cy_o == x.cy, {x.tag, " carry"}, 32'(cy_o), 32'(x.cy));
         chk(eq_o == x.eq, {x.tag, " eq"}, 32'(eq_o), 32'(x.eq));
         chk(!busy, {x.tag, " busy"}, 32'(busy), 32'd0);
         if (x.bk) chk(b_o == x.b, {x.tag, " B"}, 32'(b_o), 32'(x.b));
         if (x.ek) chk(e_o == x.e, {x.tag, " E"}, 32'(e_o), 32'(x.e));
         if (x.dk) chk(d_o == x.d, {x.tag, " D"}, 32'(d_o), 32'(x.d));
      end
   end

   // driver: one operation, expected state computed from the requirements
   task automatic op(input logic [3:0] c, input logic [3:0] m,
                     input logic [3:0] im, input string tag);
      logic [4:0] s;
      logic eq;
      @(negedge clk);
      op_code = c; mem_nib = m; imm_nib = im;
      @(posedge clk); #1;
      op_code = 4'd0;
      eq = 1'b0;
      case (c)
         4'd1: begin s = {1'b0, ma} + {1'b0, m} + {4'd0, mcy}; ma = s[3:0]; mcy = s[4]; end
         4'd2: ma = ma + im;
         4'd3: ma = ma + m;
         4'd4: ma = ma & m;
         4'd5: ma = ma | m;
         4'd6: eq = (ma == m);
         4'd7: begin s[0] = mcy; mcy = ma[0]; ma = {s[0], ma[3:1]}; end
         4'd8: mcy = 1'b1;
         4'd9: mcy = 1'b0;
         4'd10: begin me = {mb, ma}; ek = 1; end
         4'd11: begin ma = me[3:0]; mb = me[7:4]; end
         4'd12: ma = mb;
         4'd13: begin mb = ma; bk = 1; end
         default: ;
      endcase
      push(tag, eq);
   endtask

   task automatic tbl(input logic [6:0] p, input logic [9:0] dat, input int w);
      @(negedge clk);
      op_code = 4'd14; page_imm = p;
      @(posedge clk); #1;
      op_code = 4'd0;
      @(negedge clk);
      // R10: request strobe, busy and address fields
      chk(rom_req == 1'b1, "R10 req", 32'(rom_req), 32'd1);
      chk(busy == 1'b1, "R10 busy", 32'(busy), 32'd1);
      chk(rom_addr[13:7] == p, "R10 page", 32'(rom_addr[13:7]), 32'(p));
      chk(rom_addr[3:0] == ma, "R10 acc", 32'(rom_addr[3:0]), 32'(ma));
      if (dk) chk(rom_addr[6:4] == md, "R10 D", 32'(rom_addr[6:4]), 32'(md));
      for (int i = 0; i < w; i++) begin
         // R12: ops issued while waiting are dropped
         op_code = 4'd2; imm_nib = 4'd1;
         @(posedge clk); #1;
         op_code = 4'd0;
         @(negedge clk);
         chk(acc_o == ma && busy && !rom_req, "R12 busy drop",
             32'(acc_o), 32'(ma));
      end
      rom_valid = 1'b1; rom_data = dat;
      @(posedge clk); #1;
      rom_valid = 1'b0;
      ma = dat[3:0]; mb = dat[7:4]; md = {1'b0, dat[9:8]};
      bk = 1; dk = 1;
      push("R11 reply", 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(acc_o == 4'd0, "R1 acc", 32'(acc_o), 32'd0);
      chk(!cy_o, "R1 carry", 32'(cy_o), 32'd0);
      chk(!rom_req && !busy && !eq_o, "R1 strobes",
          32'({rom_req, busy, eq_o}), 32'd0);

      op(4'd4, 4'h0, 4'h0, "R4 and");
      op(4'd2, 4'h0, 4'h5, "R3 addi");
      op(4'd13, 4'h0, 4'h0, "R9 a2b");
      op(4'd2, 4'h0, 4'h3, "R3 addi");
      op(4'd10, 4'h0, 4'h0, "R8 pack");
      op(4'd1, 4'h9, 4'h0, "R2 adc carry");
      op(4'd1, 4'h0, 4'h0, "R2 adc cin");
      op(4'd8, 4'h0, 4'h0, "R7 setc");
      op(4'd3, 4'hF, 4'h0, "R3 addm");
      op(4'd2, 4'h0, 4'hE, "R3 addi wrap");
      op(4'd9, 4'h0, 4'h0, "R7 clrc");
      op(4'd2, 4'h0, 4'hF, "R3 addi no cy");
      op(4'd5, 4'hA, 4'h0, "R4 or");
      op(4'd4, 4'h6, 4'h0, "R4 and");
      op(4'd6, ma, 4'h0, "R5 cmp eq");
      op(4'd6, ma ^ 4'h1, 4'h0, "R5 cmp ne");
      op(4'd7, 4'h0, 4'h0, "R6 rar");
      op(4'd8, 4'h0, 4'h0, "R7 setc");
      op(4'd7, 4'h0, 4'h0, "R6 rar cin");
      op(4'd7, 4'h0, 4'h0, "R6 rar");
      op(4'd12, 4'h0, 4'h0, "R9 b2a");
      op(4'd11, 4'h0, 4'h0, "R8 unpack");
      op(4'd15, 4'h3, 4'h7, "R13 op15");
      op(4'd0, 4'h3, 4'h7, "R13 nop");
      op(4'd1, 4'hF, 4'h0, "R2 adc max");

      tbl(7'h55, 10'h3A7, 2);
      tbl(7'h2A, 10'h2C5, 0);
      // R12: reply pulse while idle changes nothing
      @(negedge clk);
      rom_valid = 1'b1; rom_data = 10'h3FF;
      @(posedge clk); #1;
      rom_valid = 1'b0;
      push("R12 idle reply", 1'b0);
      op(4'd13, 4'h0, 4'h0, "R9 a2b");
      op(4'd10, 4'h0, 4'h0, "R8 pack");

      repeat (3) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule